// File: doc/BRIEF.md
# Frame-Synchronized Video Control Register File

This block is the configuration register file of a video processing core. Software reaches it through a simple 32-bit write port and a 32-bit read port with a one-cycle read latency. It holds a control word, an active-size word, and thirteen processing parameters. The parameters are clip and clamp limits, offsets and matrix coefficients for an RGB to luma/chroma conversion. Every size or parameter write lands in a staging copy. The datapath sees only the active copy, and that copy takes the staged values only on a start-of-frame pulse. A frame therefore never runs with a mix of old and new settings.

The control word carries a core enable and a commit (update) enable. It also carries two reset requests. The first is immediate: it clears the configuration and holds the datapath in reset until software writes the bit back to zero. The second is deferred: it waits for the next rising edge of the vertical-blank input, clears everything in that cycle, raises the datapath reset for exactly one cycle, and then clears itself.

Top module: `vid_cfg_regfile`

## Requirements
- R1: After reset, all staged and active values are zero, the control word reads zero, `core_en` and `core_rst` are low, and offset 0x010 reads the `VERSION` parameter.
- R2: A write to the size offset or to a parameter offset updates only the staged copy. Reading that offset returns the staged value, and the active outputs keep their old value.
- R3: When control bit 0 (enable) and bit 1 (update) are both set, a `sof` pulse copies every staged value into the active set. The new values appear on the outputs in the cycle after the pulse.
- R4: A `sof` pulse leaves the active set unchanged while either control bit 0 or control bit 1 is clear.
- R5: While both bits stay set, every `sof` pulse commits again, so later staged writes reach the outputs on the following frame.
- R6: The size word at 0x020 drives `act_cols` from bits 31:16 and `act_rows` from bits 15:0 of the committed value.
- R7: Parameter k (k = 0..12) lives at byte offset 0x100 + 4k and drives `act_param[k]`. The order is Y max, Y min, Cb max, Cb min, Cr max, Cr min, Y offset, Cb offset, Cr offset, then coefficients A, B, C and D.
- R8: The control word at 0x000 keeps only bits 0, 1, 30 and 31, and all other bits read back as zero. `core_en` follows bit 0 while no reset is active.
- R9: While control bit 31 is set, `core_rst` is high and `core_en` is low. The staged and active sets are cleared from the next cycle on, and writes to them are ignored. Writing bit 31 back to 0 releases the reset.
- R10: Control bit 30 has no effect until the next rising edge of `vblank`. In that cycle, staged values, active values and the whole control word are cleared. `core_rst` is then high for exactly one cycle.
- R11: The version register at 0x010 is read-only, and writes to it do not change the value read back.
- R12: `rd_data` updates one cycle after `rd_en`. Reads of unmapped offsets return zero; these include 0x004, 0x008, 0x00C and parameter-range offsets that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| sof | input | 1 | Start-of-frame pulse |
| vblank | input | 1 | Vertical-blank level |
| core_en | output | 1 | Datapath enable |
| core_rst | output | 1 | Datapath reset |
| act_cols | output | 16 | Active column count |
| act_rows | output | 16 | Active row count |
| act_param | output | 13x32 | Active parameter set, index k as in R7 |

## Verification
The commit path is driven with `sof` pulses under the four combinations of the enable and update bits. Only the both-set case may move the outputs, which separates a missing enable gate from a missing update gate. A second staged change committed on a later frame, and a change that is not committed because update is clear, separate a one-shot commit from a per-frame commit. Each parameter gets a distinct value, so a swapped offset or index shows up. The two reset flavours are tried back to back: the deferred one is held across idle cycles before the vblank edge, and the immediate one receives writes while asserted, to confirm they are dropped.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_PARAM = 13;
  localparam int BANK_N    = NUM_PARAM + 1;
  localparam int IDX_W     = $clog2(BANK_N);

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VER   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SIZE  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_PARAM = 12'h100;

  localparam int CB_EN   = 0;
  localparam int CB_UPD  = 1;
  localparam int CB_ARST = 30;
  localparam int CB_SRST = 31;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // Bank slot 0 is the size word; slots 1..NUM_PARAM are parameters.
  function automatic slot_t bank_slot(input logic [ADDR_W-1:0] a);
    slot_t s;
    logic [ADDR_W-3:0] w;
    s = '0;
    w = a[ADDR_W-1:2] - OFS_PARAM[ADDR_W-1:2];
    if (a == OFS_SIZE) begin
      s.hit = 1'b1;
      s.idx = '0;
    end else if (a >= OFS_PARAM && a[1:0] == 2'b00 && int'(w) < NUM_PARAM) begin
      s.hit = 1'b1;
      s.idx = IDX_W'(int'(w) + 1);
    end
    return s;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_word(input logic en, input logic upd,
                                                 input logic arst, input logic srst);
    logic [REG_W-1:0] v;
    v = '0;
    v[CB_EN]   = en;
    v[CB_UPD]  = upd;
    v[CB_ARST] = arst;
    v[CB_SRST] = srst;
    return v;
  endfunction
endpackage

// File: rtl/vcr_ctrl.sv
module vcr_ctrl
  import vcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [3:0]       ctl_bits_i,   // {srst, arst, upd, en}
  input  logic             sof_i,
  input  logic             vblank_i,
  output logic [REG_W-1:0] ctl_word_o,
  output logic             bank_clr_o,
  output logic             commit_o,
  output logic             core_en_o,
  output logic             core_rst_o
);
  logic en_q, upd_q, arst_q, srst_q;
  logic vb_q, apulse_q;
  logic vb_rise, auto_fire;

  assign vb_rise   = vblank_i & ~vb_q;
  assign auto_fire = vb_rise & arst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      upd_q    <= 1'b0;
      arst_q   <= 1'b0;
      srst_q   <= 1'b0;
      vb_q     <= 1'b0;
      apulse_q <= 1'b0;
    end else begin
      vb_q     <= vblank_i;
      apulse_q <= auto_fire;
      if (auto_fire) begin
        en_q   <= 1'b0;
        upd_q  <= 1'b0;
        arst_q <= 1'b0;
        srst_q <= 1'b0;
      end else if (ctl_we_i) begin
        en_q   <= ctl_bits_i[0];
        upd_q  <= ctl_bits_i[1];
        arst_q <= ctl_bits_i[2];
        srst_q <= ctl_bits_i[3];
      end
    end
  end

  assign ctl_word_o = ctrl_word(en_q, upd_q, arst_q, srst_q);
  assign bank_clr_o = srst_q | auto_fire;
  assign commit_o   = sof_i & en_q & upd_q & ~srst_q & ~auto_fire;
  assign core_en_o  = en_q & ~srst_q & ~apulse_q;
  assign core_rst_o = srst_q | apulse_q;

  // R10
  arst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_i && !vb_q && arst_q) |=> (core_rst_o && ctl_word_o == '0));
  // R10
  arst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apulse_q |=> !apulse_q);
  // R9
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_word_o[CB_SRST] |-> (core_rst_o && !core_en_o));
endmodule

// File: rtl/vcr_bank.sv
module vcr_bank #(
  parameter int N = 14,
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 commit_i,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] widx_i,
  input  logic [W-1:0]         wdata_i,
  output logic [N-1:0][W-1:0]  stg_o,
  output logic [N-1:0][W-1:0]  act_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0][W-1:0] stg_q, act_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        stg_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (we_i && widx_i == IW'(g)) stg_q[g] <= wdata_i;
        if (commit_i) act_q[g] <= stg_q[g];
      end
    end
  end

  assign stg_o = stg_q;
  assign act_o = act_q;

  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !clr_i) |=> $stable(act_q));
  // R3
  act_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !clr_i) |=> act_q == $past(stg_q));
  // R9
  bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stg_q == '0 && act_q == '0));
endmodule

// File: rtl/vid_cfg_regfile.sv
module vid_cfg_regfile
  import vcr_pkg::*;
#(
  parameter logic [31:0] VERSION = 32'h0007_0000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [11:0]                      wr_addr,
  input  logic [31:0]                      wr_data,
  input  logic                             rd_en,
  input  logic [11:0]                      rd_addr,
  output logic [31:0]                      rd_data,
  input  logic                             sof,
  input  logic                             vblank,
  output logic                             core_en,
  output logic                             core_rst,
  output logic [15:0]                      act_cols,
  output logic [15:0]                      act_rows,
  output logic [NUM_PARAM-1:0][REG_W-1:0]  act_param
);
  slot_t                      wr_slot, rd_slot;
  logic                       ctl_we, bank_we, bank_clr, commit, rd_hit;
  logic [REG_W-1:0]           ctl_word, rd_mux, rd_q;
  logic [BANK_N-1:0][REG_W-1:0] stg_all, act_all;

  assign wr_slot = bank_slot(wr_addr);
  assign rd_slot = bank_slot(rd_addr);
  assign ctl_we  = wr_en && wr_addr == OFS_CTRL;
  assign bank_we = wr_en && wr_slot.hit;

  vcr_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we_i   (ctl_we),
    .ctl_bits_i ({wr_data[CB_SRST], wr_data[CB_ARST], wr_data[CB_UPD], wr_data[CB_EN]}),
    .sof_i      (sof),
    .vblank_i   (vblank),
    .ctl_word_o (ctl_word),
    .bank_clr_o (bank_clr),
    .commit_o   (commit),
    .core_en_o  (core_en),
    .core_rst_o (core_rst)
  );

  vcr_bank #(.N(BANK_N), .W(REG_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (bank_clr),
    .commit_i (commit),
    .we_i     (bank_we),
    .widx_i   (wr_slot.idx),
    .wdata_i  (wr_data),
    .stg_o    (stg_all),
    .act_o    (act_all)
  );

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b1;
    if (rd_addr == OFS_CTRL)      rd_mux = ctl_word;
    else if (rd_addr == OFS_VER)  rd_mux = VERSION;
    else if (rd_slot.hit)         rd_mux = stg_all[rd_slot.idx];
    else                          rd_hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data   = rd_q;
  assign act_cols  = act_all[0][31:16];
  assign act_rows  = act_all[0][15:0];
  assign act_param = act_all[BANK_N-1:1];

  // R12
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> rd_data == '0);
  // R11
  ver_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == OFS_VER) |=> rd_data == VERSION);
endmodule

// File: tb/test_vid_cfg_regfile.sv
module test_vid_cfg_regfile;
  localparam logic [31:0] EXP_VER = 32'h0007_0000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, sof = 0, vblank = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic core_en, core_rst;
  logic [15:0] act_cols, act_rows;
  logic [12:0][31:0] act_param;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vid_cfg_regfile #(.VERSION(EXP_VER)) i_vid_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sof(sof), .vblank(vblank),
    .core_en(core_en), .core_rst(core_rst), .act_cols(act_cols), .act_rows(act_rows),
    .act_param(act_param));

  function automatic logic [31:0] pval(input int k);
    return 32'h0000_0100 + 32'(k * 7);
  endfunction

  function automatic logic [11:0] pofs(input int k);
    return 12'h100 + 12'(4 * k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic frame();
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 core_en", 32'(core_en), 0);
    chk("R1 core_rst", 32'(core_rst), 0);
    chk("R1 act size", {act_cols, act_rows}, 0);
    for (int k = 0; k < 13; k++) chk("R1 act_param", act_param[k], 0);
    rd(12'h010, v); chk("R1 version", v, EXP_VER);
    rd(12'h000, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_stage();
    logic [31:0] v;
    for (int k = 0; k < 13; k++) wr(pofs(k), pval(k));
    wr(12'h020, (32'd1280 << 16) | 32'd720);
    for (int k = 0; k < 13; k++) chk("R2 active untouched", act_param[k], 0);
    chk("R2 size untouched", {act_cols, act_rows}, 0);
    for (int k = 0; k < 13; k++) begin
      rd(pofs(k), v); chk("R7 staged readback", v, pval(k));
    end
    rd(12'h020, v); chk("R2 size staged", v, (32'd1280 << 16) | 32'd720);
  endtask

  task automatic t_gating();
    frame(); chk("R4 no bits", act_param[0], 0);
    wr(12'h000, 32'h2); frame(); chk("R4 update only", act_param[0], 0);
    chk("R8 core_en off", 32'(core_en), 0);
    wr(12'h000, 32'h1); frame(); chk("R4 enable only", act_param[0], 0);
    chk("R8 core_en on", 32'(core_en), 1);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    wr(12'h000, 32'h0000_FFF3);
    rd(12'h000, v); chk("R8 ctrl mask", v, 32'h3);
    frame();
    for (int k = 0; k < 13; k++) chk("R3 R7 commit", act_param[k], pval(k));
    chk("R6 cols", 32'(act_cols), 1280);
    chk("R6 rows", 32'(act_rows), 720);
    wr(pofs(0), 32'd240);
    chk("R2 before frame", act_param[0], pval(0));
    frame(); chk("R5 second frame", act_param[0], 240);
    wr(12'h000, 32'h1);
    wr(pofs(0), 32'd99);
    frame(); chk("R4 update cleared", act_param[0], 240);
  endtask

  task automatic t_map();
    logic [31:0] v;
    rd(12'h004, v); chk("R12 0x004", v, 0);
    rd(12'h008, v); chk("R12 0x008", v, 0);
    rd(12'h00C, v); chk("R12 0x00C", v, 0);
    rd(12'h102, v); chk("R12 misaligned", v, 0);
    rd(12'h134, v); chk("R12 past params", v, 0);
    wr(12'h010, 32'hDEAD_BEEF);
    rd(12'h010, v); chk("R11 version ro", v, EXP_VER);
  endtask

  task automatic t_auto_reset();
    logic [31:0] v;
    wr(12'h000, 32'h4000_0003);
    repeat (4) @(negedge clk);
    frame();
    chk("R10 no effect before edge", 32'(core_rst), 0);
    chk("R10 act kept", act_param[0], 99);
    @(negedge clk); vblank = 1;
    @(negedge clk);
    chk("R10 pulse", 32'(core_rst), 1);
    chk("R10 act cleared", act_param[0], 0);
    chk("R10 core_en low", 32'(core_en), 0);
    @(negedge clk);
    chk("R10 pulse ends", 32'(core_rst), 0);
    vblank = 0;
    rd(12'h000, v); chk("R10 ctrl cleared", v, 0);
    rd(pofs(0), v); chk("R10 staged cleared", v, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(12'h000, 32'h3);
    wr(pofs(0), 32'd5);
    frame(); chk("R3 pre soft", act_param[0], 5);
    wr(12'h000, 32'h8000_0003);
    chk("R9 rst high", 32'(core_rst), 1);
    chk("R9 en low", 32'(core_en), 0);
    @(negedge clk);
    chk("R9 act cleared", act_param[0], 0);
    wr(pofs(0), 32'd77);
    rd(pofs(0), v); chk("R9 write ignored", v, 0);
    frame(); chk("R9 no commit", act_param[0], 0);
    rd(12'h000, v); chk("R9 ctrl held", v, 32'h8000_0003);
    chk("R9 still held", 32'(core_rst), 1);
    wr(12'h000, 32'h3);
    chk("R9 released", 32'(core_rst), 0);
    chk("R9 en back", 32'(core_en), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_gating();
    t_commit();
    t_map();
    t_auto_reset();
    t_soft_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule